// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns one PWM command into two gate-enable outputs, one for the high-side switch and one for the low-side switch of a synchronous buck stage. It never enables both switches at once. The gap between the two enables is not a fixed count. Each switch-on waits until an external comparator reports that the opposite gate has discharged below its turn-off threshold. Those comparator results arrive asynchronously, so each one passes through a two-flop synchronizer before the state machine uses it.

Fault inputs take priority over the PWM command. A general fault turns both drives off. An over-voltage fault holds the low side on, once the high side has discharged, until a release input reports that feedback has fallen low enough. A current-limit skip request suppresses the high-side pulse, so the stage behaves as if the command were low. A watchdog counter guards every wait for a discharge indicator. If the indicator does not come within a programmable number of cycles, a sticky timeout flag is raised and both drives stay off until reset.

Top module: `gate_deadtime_seq`

## Requirements
- R1: `hs_drive` and `ls_drive` are never both 1 in the same cycle.
- R2: `hs_drive` rises only when the synchronized `ls_gate_low` was 1 in the previous cycle. The synchronizer has two stages, so a raw change reaches the state machine after two clock edges.
- R3: `ls_drive` rises only when the synchronized `hs_gate_low` was 1 in the previous cycle. This applies to normal operation and to over-voltage operation.
- R4: While `fault_all` is 1, both drives are 0 from the clock edge after it is sampled high. `fault_all` has priority over every other input.
- R5: A one-cycle pulse on `ovp_fault` is latched. It turns `hs_drive` off. Once the high gate has discharged, it holds `ls_drive` at 1 regardless of `pwm_cmd`. The hold ends only when `ovp_release` is 1 and `ovp_fault` is 0.
- R6: While `skip_req` is 1, `hs_drive` does not rise, and the sequencer moves toward the low-side state as it would for `pwm_cmd` = 0.
- R7: If the sequencer waits for a discharge indicator for `tmo_limit` cycles without seeing it, `tmo_flag` becomes 1. The flag stays 1 until reset, and both drives stay 0 while it is set.
- R8: After reset, `hs_drive`, `ls_drive` and `tmo_flag` are all 0.
- R9: In normal operation, with the comparators following the gates, a steady `pwm_cmd` = 1 gives `hs_drive` = 1 and a steady `pwm_cmd` = 0 gives `ls_drive` = 1, each within a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_cmd | input | 1 | PWM command: 1 requests the high side, 0 requests the low side |
| skip_req | input | 1 | Current-limit pulse-skip request for the present cycle |
| fault_all | input | 1 | General fault: both drives off |
| ovp_fault | input | 1 | Over-voltage fault: force the low side on |
| ovp_release | input | 1 | Feedback has dropped below the release level |
| hs_gate_low | input | 1 | Asynchronous comparator: high-side gate is discharged |
| ls_gate_low | input | 1 | Asynchronous comparator: low-side gate is discharged |
| tmo_limit | input | TMO_W | Maximum number of wait cycles for a discharge indicator |
| hs_drive | output | 1 | High-side gate enable |
| ls_drive | output | 1 | Low-side gate enable |
| tmo_flag | output | 1 | Sticky discharge-timeout flag |

## Verification
The assertions check several properties on every cycle:
- mutual exclusion of the two drives;
- the link between each drive's rising edge and the synchronized opposite-gate indicator;
- the one-edge shutdown under `fault_all`;
- the ban on a high-side pulse during skip or over-voltage;
- the stickiness of the timeout flag.

Some behaviours can only be shown by bench scenarios that close the loop through a modelled gate delay:
- that the latched over-voltage hold survives a high PWM command until release;
- that normal operation really reaches each switch-on state;
- that a stuck comparator leads to a timeout after the programmed limit and not earlier.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_WAIT_LS_OFF = 3'd1,
    ST_HS_ON       = 3'd2,
    ST_WAIT_HS_OFF = 3'd3,
    ST_LS_ON       = 3'd4,
    ST_FORCED_LS   = 3'd5
  } gseq_state_e;

endpackage

// File: rtl/gseq_sync.sv
module gseq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_in[b]};
      end
    end

    assign sync_out[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/gseq_timer.sv
module gseq_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = !run || clear || (cnt_q != CNT_MAX);

  always_comb begin
    if (!run || clear) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
  import gseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  input  logic skip_req,
  input  logic fault_all,
  input  logic ovp_fault,
  input  logic ovp_release,
  input  logic hs_off_s,
  input  logic ls_off_s,
  input  logic expired,
  output logic in_wait,
  output logic state_chg,
  output logic hs_drive,
  output logic ls_drive,
  output logic tmo_flag
);

  gseq_state_e state_q, state_d;
  logic        pend_q, pend_d;
  logic        tmo_q, tmo_d;
  logic        ovp_req;
  logic        hs_req;

  assign ovp_req = ovp_fault || pend_q;
  assign hs_req  = pwm_cmd && !skip_req && !ovp_req;

  always_comb begin
    state_d = state_q;
    tmo_d   = tmo_q;
    if (fault_all || tmo_q) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (hs_req) state_d = ST_WAIT_LS_OFF;
          else        state_d = ST_WAIT_HS_OFF;
        end
        ST_WAIT_LS_OFF: begin
          if (!hs_req) begin
            state_d = ST_WAIT_HS_OFF;
          end else if (ls_off_s) begin
            state_d = ST_HS_ON;
          end else if (expired) begin
            state_d = ST_IDLE;
            tmo_d   = 1'b1;
          end
        end
        ST_HS_ON: begin
          if (!hs_req) state_d = ST_WAIT_HS_OFF;
        end
        ST_WAIT_HS_OFF: begin
          if (hs_req) begin
            state_d = ST_WAIT_LS_OFF;
          end else if (hs_off_s) begin
            state_d = ovp_req ? ST_FORCED_LS : ST_LS_ON;
          end else if (expired) begin
            state_d = ST_IDLE;
            tmo_d   = 1'b1;
          end
        end
        ST_LS_ON: begin
          if (ovp_req)     state_d = ST_FORCED_LS;
          else if (hs_req) state_d = ST_WAIT_LS_OFF;
        end
        ST_FORCED_LS: begin
          if (ovp_release && !ovp_fault) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign pend_d = (pend_q || ovp_fault) && (state_d != ST_FORCED_LS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      tmo_q   <= tmo_d;
    end
  end

  assign in_wait   = (state_q == ST_WAIT_LS_OFF) || (state_q == ST_WAIT_HS_OFF);
  assign state_chg = (state_d != state_q);
  assign hs_drive  = (state_q == ST_HS_ON);
  assign ls_drive  = (state_q == ST_LS_ON) || (state_q == ST_FORCED_LS);
  assign tmo_flag  = tmo_q;

endmodule

// File: rtl/gate_deadtime_seq.sv
module gate_deadtime_seq #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_cmd,
  input  logic             skip_req,
  input  logic             fault_all,
  input  logic             ovp_fault,
  input  logic             ovp_release,
  input  logic             hs_gate_low,
  input  logic             ls_gate_low,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             hs_drive,
  output logic             ls_drive,
  output logic             tmo_flag
);

  localparam int N_CMP = 2;

  logic [N_CMP-1:0] cmp_sync;
  logic             hs_off_s;
  logic             ls_off_s;
  logic             in_wait;
  logic             state_chg;
  logic             expired;

  gseq_sync #(.WIDTH(N_CMP), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ls_gate_low, hs_gate_low}),
    .sync_out (cmp_sync)
  );

  assign hs_off_s = cmp_sync[0];
  assign ls_off_s = cmp_sync[1];

  gseq_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (in_wait),
    .clear   (state_chg),
    .limit   (tmo_limit),
    .expired (expired)
  );

  gseq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_cmd     (pwm_cmd),
    .skip_req    (skip_req),
    .fault_all   (fault_all),
    .ovp_fault   (ovp_fault),
    .ovp_release (ovp_release),
    .hs_off_s    (hs_off_s),
    .ls_off_s    (ls_off_s),
    .expired     (expired),
    .in_wait     (in_wait),
    .state_chg   (state_chg),
    .hs_drive    (hs_drive),
    .ls_drive    (ls_drive),
    .tmo_flag    (tmo_flag)
  );

endmodule

// File: rtl/gseq_checker.sv
module gseq_checker (
  input logic clk,
  input logic rst_n,
  input logic pwm_cmd,
  input logic skip_req,
  input logic fault_all,
  input logic ovp_fault,
  input logic hs_drive,
  input logic ls_drive,
  input logic tmo_flag,
  input logic hs_off_s,
  input logic ls_off_s
);

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_drive && ls_drive));

  assert_hs_after_ls_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_drive) |-> $past(ls_off_s));

  assert_ls_after_hs_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_drive) |-> $past(hs_off_s));

  assert_fault_kills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_all |=> (!hs_drive && !ls_drive));

  assert_ovp_no_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_fault |=> !hs_drive);

  assert_ovp_hold_ls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_drive && ovp_fault && !fault_all && !tmo_flag) |=> ls_drive);

  assert_skip_blocks_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_drive) |-> $past(pwm_cmd && !skip_req));

  assert_tmo_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |=> tmo_flag);

  assert_tmo_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |-> (!hs_drive && !ls_drive));

endmodule

bind gate_deadtime_seq gseq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_cmd   (pwm_cmd),
  .skip_req  (skip_req),
  .fault_all (fault_all),
  .ovp_fault (ovp_fault),
  .hs_drive  (hs_drive),
  .ls_drive  (ls_drive),
  .tmo_flag  (tmo_flag),
  .hs_off_s  (hs_off_s),
  .ls_off_s  (ls_off_s)
);

// File: tb/gate_deadtime_seq_tb.sv
module gate_deadtime_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TMO_W      = 8;
  localparam int LIMIT      = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pwm_cmd, skip_req, fault_all, ovp_fault, ovp_release;
  logic             hs_gate_low, ls_gate_low;
  logic [TMO_W-1:0] tmo_limit;
  logic             hs_drive, ls_drive, tmo_flag;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  // bench-side stimulus intent and gate model
  logic       pwm_v, skip_v, fault_v, ovp_v, rel_v, stuck_ls;
  logic [1:0] hs_gate_pipe, ls_gate_pipe;
  logic [2:0] ls_raw_hist, hs_raw_hist;
  logic       pwm_prev, skip_prev, hs_prev, ls_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_deadtime_seq #(.TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .skip_req(skip_req),
    .fault_all(fault_all), .ovp_fault(ovp_fault), .ovp_release(ovp_release),
    .hs_gate_low(hs_gate_low), .ls_gate_low(ls_gate_low), .tmo_limit(tmo_limit),
    .hs_drive(hs_drive), .ls_drive(ls_drive), .tmo_flag(tmo_flag)
  );

  function automatic bit both_on(input logic h, input logic l);
    return h && l;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: sample at negedge, run invariant checks, then drive the next inputs
  task automatic tick(input bit inv);
    @(negedge clk);
    if (inv) begin
      check(!both_on(hs_drive, ls_drive), "R1 overlap", {hs_drive, ls_drive}, 0);
      if (hs_drive && !hs_prev) begin
        check(ls_raw_hist[2] == 1'b1, "R2 hs rise needs ls discharged", ls_raw_hist[2], 1);
        check(pwm_prev && !skip_prev, "R6 hs rise under skip or low pwm",
              {pwm_prev, skip_prev}, 2);
      end
      if (ls_drive && !ls_prev)
        check(hs_raw_hist[2] == 1'b1, "R3 ls rise needs hs discharged", hs_raw_hist[2], 1);
    end
    hs_prev      = hs_drive;
    ls_prev      = ls_drive;
    hs_gate_pipe = {hs_gate_pipe[0], !hs_drive};
    ls_gate_pipe = {ls_gate_pipe[0], !ls_drive};
    hs_gate_low  = hs_gate_pipe[1];
    ls_gate_low  = stuck_ls ? 1'b0 : ls_gate_pipe[1];
    hs_raw_hist  = {hs_raw_hist[1:0], hs_gate_low};
    ls_raw_hist  = {ls_raw_hist[1:0], ls_gate_low};
    pwm_cmd      = pwm_v;
    skip_req     = skip_v;
    fault_all    = fault_v;
    ovp_fault    = ovp_v;
    ovp_release  = rel_v;
    pwm_prev     = pwm_v;
    skip_prev    = skip_v;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pwm_v = 0; skip_v = 0; fault_v = 0; ovp_v = 0; rel_v = 0; stuck_ls = 0;
    hs_gate_pipe = 2'b11; ls_gate_pipe = 2'b11;
    hs_raw_hist = 3'b111; ls_raw_hist = 3'b111;
    hs_prev = 0; ls_prev = 0; pwm_prev = 0; skip_prev = 0;
    pwm_cmd = 0; skip_req = 0; fault_all = 0; ovp_fault = 0; ovp_release = 0;
    hs_gate_low = 1; ls_gate_low = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!hs_drive && !ls_drive && !tmo_flag, "R8 reset state",
          {hs_drive, ls_drive, tmo_flag}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    tmo_limit = TMO_W'(LIMIT);
    do_reset();

    // R9 normal operation
    pwm_v = 1; run(12);
    check(hs_drive == 1 && ls_drive == 0, "R9 pwm high gives hs", hs_drive, 1);
    pwm_v = 0; run(12);
    check(ls_drive == 1 && hs_drive == 0, "R9 pwm low gives ls", ls_drive, 1);
    check(tmo_flag == 0, "R7 no false timeout", tmo_flag, 0);

    // R6 pulse skipping
    pwm_v = 1; skip_v = 1; run(12);
    check(hs_drive == 0, "R6 skip suppresses hs", hs_drive, 0);
    check(ls_drive == 1, "R6 skip keeps ls", ls_drive, 1);
    skip_v = 0; run(12);
    check(hs_drive == 1, "R6 hs returns after skip", hs_drive, 1);

    // R4 general fault
    fault_v = 1; tick(1'b1);
    tick(1'b1);
    check(!hs_drive && !ls_drive, "R4 fault edge off", {hs_drive, ls_drive}, 0);
    run(6);
    check(!hs_drive && !ls_drive, "R4 fault held off", {hs_drive, ls_drive}, 0);
    fault_v = 0; run(12);
    check(hs_drive == 1, "R4 resume after fault", hs_drive, 1);

    // R5 over-voltage pulse with pwm still high
    ovp_v = 1; tick(1'b1);
    ovp_v = 0; tick(1'b1);
    check(hs_drive == 0, "R5 ovp turns hs off", hs_drive, 0);
    run(10);
    check(ls_drive == 1 && hs_drive == 0, "R5 ovp forces ls", ls_drive, 1);
    run(15);
    check(ls_drive == 1, "R5 ovp held until release", ls_drive, 1);
    rel_v = 1; ovp_v = 1; tick(1'b1);
    rel_v = 1; ovp_v = 0; run(2);
    check(ls_drive == 0 && hs_drive == 0, "R5 release exits hold", {hs_drive, ls_drive}, 0);
    rel_v = 0; run(12);
    check(hs_drive == 1, "R5 normal after release", hs_drive, 1);

    // constrained random closed-loop phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 11) == 0) pwm_v = !pwm_v;
      skip_v  = ($urandom_range(0, 7) == 0);
      fault_v = ($urandom_range(0, 63) == 0);
      ovp_v   = ($urandom_range(0, 199) == 0);
      rel_v   = ($urandom_range(0, 39) == 0);
      tick(1'b1);
      if (tmo_flag) check(1'b0, "R7 false timeout in closed loop", tmo_flag, 0);
    end
    fault_v = 0; ovp_v = 0; skip_v = 0;
    rel_v = 1; tick(1'b1); rel_v = 0;
    pwm_v = 0; run(20);
    check(ls_drive == 1, "R9 ls after random phase", ls_drive, 1);

    // R7 timeout: low-side comparator stuck, high side requested
    stuck_ls = 1; pwm_v = 1; run(10);
    check(tmo_flag == 0 && hs_drive == 0, "R7 no timeout before limit", tmo_flag, 0);
    run(LIMIT + 5);
    check(tmo_flag == 1, "R7 timeout raised", tmo_flag, 1);
    check(!hs_drive && !ls_drive, "R7 drives off on timeout", {hs_drive, ls_drive}, 0);
    stuck_ls = 0;
    for (int i = 0; i < 6; i++) begin
      pwm_v = !pwm_v; run(5);
    end
    check(tmo_flag == 1 && !hs_drive && !ls_drive, "R7 timeout sticky",
          {tmo_flag, hs_drive, ls_drive}, 4);

    do_reset();
    check(tmo_flag == 0, "R8 reset clears timeout", tmo_flag, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule